// File: doc/BRIEF.md
# Result Sign Resolution Stage

This stage sits at the end of a decimal add/subtract pipeline built from per-digit spike counts. It gathers residue and carry counts for each decimal lane into running per-lane totals, folds every lane above the lowest back into the range 0..9, and decides the sign of the result by counting how many completion flags arrive together. Two coincident flags mean the sum already has the right form: the lane totals go out as the result with a positive sign pulse. A single flag means the sum is in complemented form: the totals go back to the complement stage as a re-complement request, and a delay unit inside the block starts to run.

The delay unit stands in for the auxiliary path. A fixed number of cycles after the request is accepted, it returns a flag, and a little later a positive and a negative sign spike. On this second pass, the returned flag and the adder's own flag together force the release of the freshly accumulated lanes. At release the block's own positive tag meets the returned positive spike, and the two cancel, so only the negative sign pulse leaves the block. After either release, a one-cycle done strobe fires and the block ignores all further traffic until reset.

All three data interfaces are valid/ready streams. A beat moves only in a cycle where valid and ready are both high. `in_ready` is low while a re-complement request or a result is waiting. Once a stream's valid is high, it stays high and its payload stays unchanged until the beat is taken. The sign pulses and the done strobe are plain, unregistered outputs that fire in the cycle the result is taken.

Top module: `sign_resolve`

## Requirements
- R1: After reset, `out_valid`, `rc_valid`, `pos_pulse`, `neg_pulse` and `done` are low, `in_ready` is high and every lane total is zero.
- R2: Each accepted input beat adds lane i of `in_cnt` (bits [i*CW +: CW], lane 0 least significant) to lane total i. Lane 0 is never folded and wraps modulo 2^CW.
- R3: For lanes 1 and up, a sum of 10 or more is reduced by 10 when it is stored. Legal input keeps each such sum at or below 19, so these totals stay within 0..9.
- R4: `in_flags` gives the number of flags that arrive with a beat. 0 means none, 1 means one, and 2 or 3 mean two. In the first pass, an accepted beat with two flags raises `out_valid` in the next cycle. `out_digits` then holds the lane totals, including that beat.
- R5: In the first pass, an accepted beat with exactly one flag raises `rc_valid` in the next cycle, with the lane totals on `rc_digits`. `in_ready` is low while `rc_valid` is high. When the request is taken, all lane totals are cleared and the second pass begins.
- R6: The returned flag is due AUX_DLY+FLAG_DLY cycles after the request is taken, and the returned sign spikes are due AUX_DLY+SIGN_DLY cycles after it. If the adder flag has already arrived, `out_valid` rises exactly AUX_DLY+SIGN_DLY+1 cycles after the request handshake (37 with the defaults).
- R7: In the second pass, the release needs the adder flag (any nonzero `in_flags` on an accepted beat) as well as the returned spikes. If the adder flag comes after them, `out_valid` rises in the cycle after that beat. With no adder flag, no result is ever raised.
- R8: When a result is taken, a first-pass result gives `pos_pulse`=1 and `neg_pulse`=0. A second-pass result gives `neg_pulse`=1 and `pos_pulse`=0, because the two positive spikes cancel.
- R9: While `out_valid` or `rc_valid` is high and the matching ready is low, the valid stays high and the payload does not change.
- R10: `done` is high for exactly one cycle, the cycle in which the result is taken and the sign pulse fires.
- R11: After `done`, input beats are still accepted (`in_ready` high) but have no effect. `out_valid`, `rc_valid`, the pulses and `done` stay low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat ready |
| in_cnt | input | N*CW | Per-lane spike counts of the beat |
| in_flags | input | 2 | Number of coincident flags with the beat |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result ready |
| out_digits | output | N*CW | Result lane totals |
| rc_valid | output | 1 | Re-complement request valid |
| rc_ready | input | 1 | Re-complement request ready |
| rc_digits | output | N*CW | Lane totals sent back for re-complement |
| pos_pulse | output | 1 | Positive sign pulse when the result is taken |
| neg_pulse | output | 1 | Negative sign pulse when the result is taken |
| done | output | 1 | One-cycle completion strobe |

## Verification
A first-pass result or request is due one cycle after the flagged beat is accepted. The bench drives inputs on falling edges and samples on the next falling edge, so it sees the registered valid exactly one edge later. The second-pass result is due 37 edges after the request handshake when the adder flag came early, and one edge after the flagged beat when it came late. The bench counts rising edges with its own counter from the handshake and compares that count with the value given by the delay parameters. The sign pulses and done are combinational on the handshake, so they are checked in the same half-cycle in which `out_ready` is raised, and checked low again one cycle later.

// File: rtl/sres_pkg.sv
`timescale 1ns/1ps
package sres_pkg;
  localparam int DIGIT_BASE = 10;

  typedef enum logic [2:0] {
    PH_ACC   = 3'd0,  // first pass, collecting lanes
    PH_RC    = 3'd1,  // re-complement request pending
    PH_WAIT2 = 3'd2,  // second pass, waiting for flags
    PH_OUT   = 3'd3,  // result pending
    PH_HALT  = 3'd4   // finished, inputs ignored
  } phase_e;
endpackage

// File: rtl/sres_lane.sv
`timescale 1ns/1ps
module sres_lane #(
  parameter int CW   = 5,
  parameter bit NORM = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic [CW-1:0] add_val,
  output logic [CW-1:0] cnt
);
  import sres_pkg::*;

  logic [CW-1:0] cnt_q;
  logic [CW:0]   sum;
  logic [CW:0]   folded;

  always_comb begin
    sum    = {1'b0, cnt_q} + {1'b0, add_val};
    folded = sum;
    if (NORM && (sum >= (CW+1)'(DIGIT_BASE)))
      folded = sum - (CW+1)'(DIGIT_BASE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (add_en)   cnt_q <= folded[CW-1:0];
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sres_aux_timer.sv
`timescale 1ns/1ps
module sres_aux_timer #(
  parameter int FLAG_T = 34,
  parameter int SIGN_T = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic flag_back,
  output logic sign_back
);
  localparam int TW = $clog2(SIGN_T + 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_nxt;
  logic          flag_q;
  logic          sign_q;

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      sign_q <= 1'b0;
    end else if (run && !sign_q) begin
      cnt_q <= cnt_nxt;
      if (cnt_nxt == TW'(FLAG_T)) flag_q <= 1'b1;
      if (cnt_nxt == TW'(SIGN_T)) sign_q <= 1'b1;
    end
  end

  assign flag_back = flag_q;
  assign sign_back = sign_q;
endmodule

// File: rtl/sign_resolve.sv
`timescale 1ns/1ps
module sign_resolve #(
  parameter int N        = 3,
  parameter int CW       = 5,
  parameter int AUX_DLY  = 25,
  parameter int FLAG_DLY = 9,
  parameter int SIGN_DLY = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N*CW-1:0] in_cnt,
  input  logic [1:0]    in_flags,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [N*CW-1:0] out_digits,
  output logic          rc_valid,
  input  logic          rc_ready,
  output logic [N*CW-1:0] rc_digits,
  output logic          pos_pulse,
  output logic          neg_pulse,
  output logic          done
);
  import sres_pkg::*;

  localparam int VW = N * CW;

  phase_e        phase_q, phase_d;
  logic          adder_flag_q;
  logic [VW-1:0] acc;
  logic          beat_fire, rc_fire, out_fire;
  logic          beat_any, beat_two, beat_one;
  logic          aux_flag, aux_sign, release2;
  logic          own_pos;

  // lane totals: lane 0 raw, upper lanes folded
  for (genvar g = 0; g < N; g++) begin : g_lane
    sres_lane #(.CW(CW), .NORM(g > 0)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (rc_fire),
      .add_en  (beat_fire),
      .add_val (in_cnt[g*CW +: CW]),
      .cnt     (acc[g*CW +: CW])
    );
  end

  sres_aux_timer #(
    .FLAG_T (AUX_DLY + FLAG_DLY),
    .SIGN_T (AUX_DLY + SIGN_DLY)
  ) u_aux (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (rc_fire),
    .run       (phase_q == PH_WAIT2),
    .flag_back (aux_flag),
    .sign_back (aux_sign)
  );

  assign in_ready  = (phase_q == PH_ACC) || (phase_q == PH_WAIT2) ||
                     (phase_q == PH_HALT);
  assign beat_fire = in_valid && in_ready && (phase_q != PH_HALT);
  assign beat_any  = in_flags != 2'd0;
  assign beat_two  = in_flags[1];
  assign beat_one  = in_flags == 2'd1;

  assign out_valid  = phase_q == PH_OUT;
  assign rc_valid   = phase_q == PH_RC;
  assign out_digits = acc;
  assign rc_digits  = acc;
  assign out_fire   = out_valid && out_ready;
  assign rc_fire    = rc_valid && rc_ready;

  // second pass: adder flag plus returned flag and sign spikes
  assign release2 = (phase_q == PH_WAIT2) && aux_flag && aux_sign &&
                    (adder_flag_q || (beat_fire && beat_any));

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_ACC: begin
        if (beat_fire && beat_two)      phase_d = PH_OUT;
        else if (beat_fire && beat_one) phase_d = PH_RC;
      end
      PH_RC:    if (rc_ready)  phase_d = PH_WAIT2;
      PH_WAIT2: if (release2)  phase_d = PH_OUT;
      PH_OUT:   if (out_ready) phase_d = PH_HALT;
      default:  phase_d = PH_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q      <= PH_ACC;
      adder_flag_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if ((phase_q == PH_WAIT2) && beat_fire && beat_any)
        adder_flag_q <= 1'b1;
    end
  end

  // own positive tag meets the returned positive spike: they cancel
  assign own_pos   = 1'b1;
  assign pos_pulse = out_fire && (own_pos ^ aux_sign);
  assign neg_pulse = out_fire && aux_sign;
  assign done      = out_fire;
endmodule

// File: rtl/sign_resolve_chk.sv
`timescale 1ns/1ps
module sign_resolve_chk #(
  parameter int N  = 3,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [N*CW-1:0] out_digits,
  input logic          rc_valid,
  input logic          rc_ready,
  input logic [N*CW-1:0] rc_digits,
  input logic          pos_pulse,
  input logic          neg_pulse,
  input logic          done
);
  logic seen_done;
  logic upper_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)    seen_done <= 1'b0;
    else if (done) seen_done <= 1'b1;
  end

  always_comb begin
    upper_ok = 1'b1;
    for (int i = 1; i < N; i++)
      if (out_digits[i*CW +: CW] > CW'(9)) upper_ok = 1'b0;
  end

  // R8
  sign_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_pulse && neg_pulse));
  // R10
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_digits)));
  // R9
  rc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_valid && !rc_ready) |=> (rc_valid && $stable(rc_digits)));
  // R5
  rc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rc_valid |-> !in_ready);
  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_done |-> (!out_valid && !rc_valid && !done && in_ready));
  // R3
  upper_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> upper_ok);
endmodule

bind sign_resolve sign_resolve_chk #(.N(N), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_digits (out_digits),
  .rc_valid   (rc_valid),
  .rc_ready   (rc_ready),
  .rc_digits  (rc_digits),
  .pos_pulse  (pos_pulse),
  .neg_pulse  (neg_pulse),
  .done       (done)
);

// File: tb/sign_resolve_bench.sv
`timescale 1ns/1ps
module sign_resolve_bench;
  localparam int N  = 3;
  localparam int CW = 5;
  localparam int VW = N * CW;
  // request handshake -> result valid, adder flag early: 25 + 11 + 1
  localparam int NEG_LAT = 37;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] in_cnt = '0;
  logic [1:0]    in_flags = 2'd0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [VW-1:0] out_digits;
  logic          rc_valid;
  logic          rc_ready = 1'b0;
  logic [VW-1:0] rc_digits;
  logic          pos_pulse, neg_pulse, done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sign_resolve u_sign_resolve (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cnt(in_cnt), .in_flags(in_flags), .out_valid(out_valid),
    .out_ready(out_ready), .out_digits(out_digits), .rc_valid(rc_valid),
    .rc_ready(rc_ready), .rc_digits(rc_digits), .pos_pulse(pos_pulse),
    .neg_pulse(neg_pulse), .done(done)
  );

  function automatic logic [VW-1:0] pk(int d0, int d1, int d2);
    return {CW'(d2), CW'(d1), CW'(d0)};
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; rc_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // leaves the bench at the falling edge after the accepting edge
  task automatic send(logic [VW-1:0] c, logic [1:0] f);
    @(negedge clk);
    in_valid = 1'b1; in_cnt = c; in_flags = f;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_flags = 2'd0;
  endtask

  task automatic take_out(logic [VW-1:0] exp, bit ep, bit en, string req);
    check(out_valid == 1'b1, {req, " out_valid"}, out_valid, 1);
    check(out_digits == exp, {req, " digits"}, out_digits, exp);
    out_ready = 1'b1;
    #1;
    check(pos_pulse == ep, {req, " pos_pulse"}, pos_pulse, ep);
    check(neg_pulse == en, {req, " neg_pulse"}, neg_pulse, en);
    check(done == 1'b1, "R10 done with sign", done, 1);
    @(negedge clk);
    out_ready = 1'b0;
    check(done == 1'b0 && out_valid == 1'b0, "R10 done one cycle", done, 0);
  endtask

  // first part of 3.12 - 5.71: single flag, request [1,4,7]
  task automatic first_pass_neg(output int hs_cyc);
    send(pk(1,3,7), 2'd0);
    send(pk(0,1,0), 2'd1);
    check(rc_valid == 1'b1, "R5 rc_valid next cycle", rc_valid, 1);
    check(rc_digits == pk(1,4,7), "R5 rc_digits", rc_digits, pk(1,4,7));
    check(in_ready == 1'b0, "R5 in_ready low", in_ready, 0);
    repeat (2) @(negedge clk);
    check(rc_valid && rc_digits == pk(1,4,7), "R9 rc held", rc_digits, pk(1,4,7));
    rc_ready = 1'b1;
    @(negedge clk);
    rc_ready = 1'b0;
    hs_cyc = cyc;
    check(rc_valid == 1'b0, "R5 rc taken", rc_valid, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check(!out_valid && !rc_valid, "R1 valids low", {out_valid, rc_valid}, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(!pos_pulse && !neg_pulse && !done, "R1 pulses low",
          {pos_pulse, neg_pulse, done}, 0);
    send(pk(0,0,0), 2'd2);
    take_out(pk(0,0,0), 1'b1, 1'b0, "R1 zero totals");
  endtask

  task automatic t_add();   // 2.63 + 3.24 = +5.87
    do_reset();
    send(pk(7,8,5), 2'd2);
    take_out(pk(7,8,5), 1'b1, 1'b0, "R4 add");
  endtask

  task automatic t_sub_pos(); // 6.4 - 5.0 = +1.4, with back-pressure
    do_reset();
    send(pk(4,1,0), 2'd0);
    check(out_valid == 1'b0, "R2 no flag no result", out_valid, 0);
    send(pk(0,0,0), 2'd2);
    repeat (3) @(negedge clk);
    check(out_valid && out_digits == pk(4,1,0), "R9 out held",
          out_digits, pk(4,1,0));
    take_out(pk(4,1,0), 1'b1, 1'b0, "R4 6.4-5.0");
  endtask

  task automatic t_fold();  // 3.27 - 3.15 = +0.12, lane 2 folds 10 -> 0
    do_reset();
    send(pk(2,0,9), 2'd0);
    send(pk(0,1,1), 2'd2);
    take_out(pk(2,1,0), 1'b1, 1'b0, "R3 fold to 0.12");
  endtask

  task automatic t_lane0(); // lane 0 raw 12, lane 1 folds 12 -> 2; flags 3
    do_reset();
    send(pk(7,3,0), 2'd0);
    send(pk(5,9,0), 2'd3);
    take_out(pk(12,2,0), 1'b1, 1'b0, "R2 lane0 raw R4 flags3");
  endtask

  task automatic t_neg_early(); // 3.12 - 5.71 = -2.59
    int hs, n;
    do_reset();
    first_pass_neg(hs);
    send(pk(9,5,2), 2'd1);
    n = 0;
    while (!out_valid && n < 200) begin @(negedge clk); n++; end
    check(cyc - hs == NEG_LAT, "R6 second pass latency", cyc - hs, NEG_LAT);
    take_out(pk(9,5,2), 1'b0, 1'b1, "R8 negative");
  endtask

  task automatic t_neg_late();
    int hs;
    do_reset();
    first_pass_neg(hs);
    repeat (50) @(negedge clk);
    check(out_valid == 1'b0, "R7 no adder flag", out_valid, 0);
    send(pk(9,5,2), 2'd0);
    check(out_valid == 1'b0, "R7 flagless beat", out_valid, 0);
    send(pk(0,0,0), 2'd1);
    check(out_valid == 1'b1, "R7 late flag release", out_valid, 1);
    take_out(pk(9,5,2), 1'b0, 1'b1, "R8 late negative");
  endtask

  task automatic t_halt();
    bit quiet;
    do_reset();
    send(pk(1,1,1), 2'd2);
    take_out(pk(1,1,1), 1'b1, 1'b0, "R11 pre");
    send(pk(3,3,3), 2'd2);
    send(pk(3,3,3), 2'd1);
    check(in_ready == 1'b1, "R11 in_ready", in_ready, 1);
    quiet = 1'b1;
    out_ready = 1'b1; rc_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1;
      if (out_valid || rc_valid || pos_pulse || neg_pulse || done) quiet = 1'b0;
      @(negedge clk);
    end
    out_ready = 1'b0; rc_ready = 1'b0;
    check(quiet, "R11 ignored after done", quiet, 1);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub_pos();
    t_fold();
    t_lane0();
    t_neg_early();
    t_neg_late();
    t_halt();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule